// File: doc/BRIEF.md
# Display Power-State Command Sequencer

This block steps a small TFT panel controller through its power modes by feeding a serial register writer. It keeps one of three panel states: disabled, active or suspended. Four request pulses move it between them: enable, disable, suspend and resume. Each accepted request plays back a fixed run of register writes from an internal constant step table. Each step holds a kind, an 8-bit address, up to 16 bits of data and a flag that asks for a millisecond pause after the write.

The state machine has five states:

- `F_BOOT`: the power-up settling wait.
- `F_IDLE`: waits for a request.
- `F_ISSUE`: presents one write and holds it until the writer acknowledges it.
- `F_GAP`: the millisecond pause.
- `F_FINISH`: commits the new panel state and reports the result.

The transitions are:

- `F_BOOT` goes to `F_IDLE` when the boot timer expires.
- `F_IDLE` goes to `F_ISSUE` when a request is accepted.
- From `F_ISSUE`, an acknowledged write goes to `F_GAP` if its step asks for a pause, to `F_FINISH` if it was the last step, and otherwise stays in `F_ISSUE` for the next step.
- `F_GAP` goes to `F_ISSUE` when the timer expires, or to `F_FINISH` if the paused step was the last one.
- `F_FINISH` always goes to `F_IDLE`.

The block also drives a video-output enable. It raises that enable once the panel is switched on, and drops it before any power-down writes go out. Writer errors are ORed over a whole sequence. The result is reported per request and also kept in a sticky bit. All millisecond waits come from one prescaled timer derived from the `CLK_HZ` parameter, so simulation can use a slow nominal clock.

Top module: `pwrseq_top`

## Requirements
- R1: During and after reset, `panel_state` is disabled (code 0), `video_en` is 0, `busy` is 1 and `wr_req` is 0.
- R2: After reset the block stays busy for BOOT_MS milliseconds (default 90) and issues no write. Any request in that window is ignored.
- R3: Write kinds are coded 0 = command only, 1 = 8-bit data, 2 = 16-bit data. An enable from disabled or suspended first sends command-only 0x00 three times, with a GAP_MS pause after each. It then writes 0xB0 = 0x17, and then runs the R4 list.
- R4: The switch-on list, also used alone by resume from suspended, is in this order: 0xBC = 0x80, 0x3B = 0x00, 0xB0 = 0x16, 16-bit 0xB8 = 0xFFF9, command 0x11, 0xBA = 0x01, 0x3A = 0x60, 0xBD = 0x04, command 0x29.
- R5: After an enable or resume sequence, `panel_state` is active (code 1) and `video_en` is 1. `video_en` is never 1 unless the state is active.
- R6: A suspend from active clears `video_en` on the acceptance edge. It then sends command 0x28, 16-bit 0xB8 = 0x8002 and command 0x10, and the state becomes suspended (code 2).
- R7: A disable from active or suspended runs the R6 list, then writes 0xB0 = 0x00, and the state becomes disabled.
- R8: The following requests do nothing: enable while active, resume unless suspended, suspend unless active, disable while disabled, and any request while busy.
- R9: When several requests arrive in the same idle cycle, disable wins over suspend, suspend over enable, and enable over resume.
- R10: `seq_fail` gives the OR of `wr_err` over every write of the last sequence. `err_sticky` collects every failure until reset.
- R11: `wr_req` and the kind, address and data stay stable until `wr_done`. `wr_req` is 0 whenever the block is not busy.
- R12: `seq_done` pulses for exactly one cycle when a sequence ends, and `busy` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_enable | input | 1 | Request: power up to active |
| req_disable | input | 1 | Request: power down to disabled |
| req_suspend | input | 1 | Request: active to suspended |
| req_resume | input | 1 | Request: suspended to active |
| wr_req | output | 1 | Write request to the serial writer |
| wr_kind | output | 2 | 0 command, 1 byte, 2 half-word |
| wr_addr | output | 8 | Register or command code |
| wr_data | output | 16 | Write data |
| wr_done | input | 1 | Writer finished the current write |
| wr_err | input | 1 | Error flag, valid with wr_done |
| busy | output | 1 | Sequencer not idle |
| panel_state | output | 2 | 0 disabled, 1 active, 2 suspended |
| video_en | output | 1 | Video output enable |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| seq_fail | output | 1 | Error result of the last sequence |
| err_sticky | output | 1 | Any failure since reset |

## Verification
The bound assertions check the following on every cycle:
- Each presented write holds steady until it is acknowledged.
- No write appears while idle.
- Video output is never on outside the active state.
- The end pulse lasts one cycle and is seen only when idle.
- The error bit never clears once set.

The bench scenarios cover what a cycle-local property cannot:
- The exact order and values of every write list.
- The boot wait length.
- The millisecond pauses after the null commands.
- Requests ignored in each state.
- Arbitration between simultaneous requests.
- OR-ing of a single injected writer error into the request result.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        K_CMD = 2'd0,
        K_W8  = 2'd1,
        K_W16 = 2'd2
    } wr_kind_e;

    typedef enum logic [1:0] {
        PS_OFF  = 2'd0,
        PS_ON   = 2'd1,
        PS_SUSP = 2'd2
    } pstate_e;

    typedef struct packed {
        wr_kind_e    kind;
        logic [7:0]  addr;
        logic [15:0] data;
        logic        gap;
    } step_t;

    localparam int N_STEPS = 17;
    localparam int IDXW    = $clog2(N_STEPS);

    // Segment boundaries of the step table; the order inside each is behaviour.
    localparam logic [IDXW-1:0] IX_WAKE    = IDXW'(0);
    localparam logic [IDXW-1:0] IX_SWON    = IDXW'(4);
    localparam logic [IDXW-1:0] IX_SWON_Z  = IDXW'(12);
    localparam logic [IDXW-1:0] IX_DOWN    = IDXW'(13);
    localparam logic [IDXW-1:0] IX_DOWN_Z  = IDXW'(15);
    localparam logic [IDXW-1:0] IX_OFF_Z   = IDXW'(16);

    function automatic step_t mk(wr_kind_e k, logic [7:0] a, logic [15:0] d, logic g);
        step_t s;
        s.kind = k;
        s.addr = a;
        s.data = d;
        s.gap  = g;
        return s;
    endfunction

    function automatic step_t step_at(logic [IDXW-1:0] ix);
        step_t s;
        unique case (ix)
            // wake ladder: null commands with pauses, then leave deep standby
            IDXW'(0), IDXW'(1), IDXW'(2): s = mk(K_CMD, 8'h00, 16'h0000, 1'b1);
            IDXW'(3):  s = mk(K_W8,  8'hB0, 16'h0017, 1'b0);
            // switch-on list
            IDXW'(4):  s = mk(K_W8,  8'hBC, 16'h0080, 1'b0);
            IDXW'(5):  s = mk(K_W8,  8'h3B, 16'h0000, 1'b0);
            IDXW'(6):  s = mk(K_W8,  8'hB0, 16'h0016, 1'b0);
            IDXW'(7):  s = mk(K_W16, 8'hB8, 16'hFFF9, 1'b0);
            IDXW'(8):  s = mk(K_CMD, 8'h11, 16'h0000, 1'b0);
            IDXW'(9):  s = mk(K_W8,  8'hBA, 16'h0001, 1'b0);
            IDXW'(10): s = mk(K_W8,  8'h3A, 16'h0060, 1'b0);
            IDXW'(11): s = mk(K_W8,  8'hBD, 16'h0004, 1'b0);
            IDXW'(12): s = mk(K_CMD, 8'h29, 16'h0000, 1'b0);
            // power-down list
            IDXW'(13): s = mk(K_CMD, 8'h28, 16'h0000, 1'b0);
            IDXW'(14): s = mk(K_W16, 8'hB8, 16'h8002, 1'b0);
            IDXW'(15): s = mk(K_CMD, 8'h10, 16'h0000, 1'b0);
            // teardown tail
            IDXW'(16): s = mk(K_W8,  8'hB0, 16'h0000, 1'b0);
            default:   s = mk(K_CMD, 8'h00, 16'h0000, 1'b0);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pwrseq_steprom.sv
module pwrseq_steprom
    import pwrseq_pkg::*;
(
    input  logic [IDXW-1:0] idx,
    output step_t           step
);
    always_comb step = step_at(idx);
endmodule

// File: rtl/pwrseq_mstimer.sv
module pwrseq_mstimer #(
    parameter int unsigned CYC_PER_MS = 100000,
    parameter int unsigned MAX_MS     = 90
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run,
    input  logic [$clog2(MAX_MS+1)-1:0] limit,
    output logic                        expired
);
    localparam int PW  = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam int MSW = $clog2(MAX_MS + 1);
    localparam logic [PW-1:0] PRE_TOP = PW'(CYC_PER_MS - 1);

    logic [PW-1:0]  pre_q;
    logic [MSW-1:0] ms_q;

    assign expired = run && (ms_q == limit);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (ms_q != limit) begin
            if (pre_q == PRE_TOP) begin
                pre_q <= '0;
                ms_q  <= ms_q + MSW'(1);
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/pwrseq_reqdec.sv
module pwrseq_reqdec
    import pwrseq_pkg::*;
(
    input  logic            idle,
    input  pstate_e         cur,
    input  logic            req_enable,
    input  logic            req_disable,
    input  logic            req_suspend,
    input  logic            req_resume,
    output logic            accept,
    output logic [IDXW-1:0] first_ix,
    output logic [IDXW-1:0] last_ix,
    output pstate_e         target
);
    always_comb begin
        accept   = 1'b0;
        first_ix = IX_WAKE;
        last_ix  = IX_SWON_Z;
        target   = cur;
        if (idle) begin
            if (req_disable && cur != PS_OFF) begin
                accept = 1'b1; first_ix = IX_DOWN; last_ix = IX_OFF_Z;  target = PS_OFF;
            end else if (req_suspend && cur == PS_ON) begin
                accept = 1'b1; first_ix = IX_DOWN; last_ix = IX_DOWN_Z; target = PS_SUSP;
            end else if (req_enable && cur != PS_ON) begin
                accept = 1'b1; first_ix = IX_WAKE; last_ix = IX_SWON_Z; target = PS_ON;
            end else if (req_resume && cur == PS_SUSP) begin
                accept = 1'b1; first_ix = IX_SWON; last_ix = IX_SWON_Z; target = PS_ON;
            end
        end
    end
endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned BOOT_MS = 90,
    parameter int unsigned GAP_MS  = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_enable,
    input  logic        req_disable,
    input  logic        req_suspend,
    input  logic        req_resume,
    output logic        wr_req,
    output logic [1:0]  wr_kind,
    output logic [7:0]  wr_addr,
    output logic [15:0] wr_data,
    input  logic        wr_done,
    input  logic        wr_err,
    output logic        busy,
    output logic [1:0]  panel_state,
    output logic        video_en,
    output logic        seq_done,
    output logic        seq_fail,
    output logic        err_sticky
);
    localparam int unsigned CYC_PER_MS = (CLK_HZ >= 1000) ? CLK_HZ / 1000 : 1;
    localparam int unsigned MAX_MS     = (BOOT_MS > GAP_MS) ? BOOT_MS : GAP_MS;
    localparam int          MSW        = $clog2(MAX_MS + 1);

    typedef enum logic [2:0] {
        F_BOOT, F_IDLE, F_ISSUE, F_GAP, F_FINISH
    } fsm_e;

    fsm_e            fsm_q, fsm_d;
    logic [IDXW-1:0] idx_q, end_q;
    pstate_e         tgt_q, pst_q;
    logic            acc_err_q;
    step_t           step;
    logic            tmr_exp;
    logic            accept;
    logic [IDXW-1:0] first_ix, last_ix;
    pstate_e         tgt_d;
    logic            at_end;

    pwrseq_steprom u_rom (.idx(idx_q), .step(step));

    pwrseq_mstimer #(.CYC_PER_MS(CYC_PER_MS), .MAX_MS(MAX_MS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (fsm_q == F_BOOT || fsm_q == F_GAP),
        .limit   ((fsm_q == F_BOOT) ? MSW'(BOOT_MS) : MSW'(GAP_MS)),
        .expired (tmr_exp)
    );

    pwrseq_reqdec u_dec (
        .idle        (fsm_q == F_IDLE),
        .cur         (pst_q),
        .req_enable  (req_enable),
        .req_disable (req_disable),
        .req_suspend (req_suspend),
        .req_resume  (req_resume),
        .accept      (accept),
        .first_ix    (first_ix),
        .last_ix     (last_ix),
        .target      (tgt_d)
    );

    assign at_end = (idx_q == end_q);

    // next-state logic
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            F_BOOT:   if (tmr_exp) fsm_d = F_IDLE;
            F_IDLE:   if (accept)  fsm_d = F_ISSUE;
            F_ISSUE:  if (wr_done) fsm_d = step.gap ? F_GAP : (at_end ? F_FINISH : F_ISSUE);
            F_GAP:    if (tmr_exp) fsm_d = at_end ? F_FINISH : F_ISSUE;
            F_FINISH: fsm_d = F_IDLE;
            default:  fsm_d = F_BOOT;
        endcase
    end

    // state register and sequence bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q     <= F_BOOT;
            idx_q     <= '0;
            end_q     <= '0;
            tgt_q     <= PS_OFF;
            acc_err_q <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
            if (fsm_q == F_IDLE && accept) begin
                idx_q     <= first_ix;
                end_q     <= last_ix;
                tgt_q     <= tgt_d;
                acc_err_q <= 1'b0;
            end
            if (fsm_q == F_ISSUE && wr_done) begin
                acc_err_q <= acc_err_q | wr_err;
                if (!step.gap && !at_end) idx_q <= idx_q + IDXW'(1);
            end
            if (fsm_q == F_GAP && tmr_exp && !at_end) idx_q <= idx_q + IDXW'(1);
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pst_q      <= PS_OFF;
            video_en   <= 1'b0;
            seq_done   <= 1'b0;
            seq_fail   <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            seq_done <= 1'b0;
            if (fsm_q == F_IDLE && accept && tgt_d != PS_ON) video_en <= 1'b0;
            if (fsm_q == F_FINISH) begin
                pst_q      <= tgt_q;
                seq_done   <= 1'b1;
                seq_fail   <= acc_err_q;
                err_sticky <= err_sticky | acc_err_q;
                if (tgt_q == PS_ON) video_en <= 1'b1;
            end
        end
    end

    assign wr_req      = (fsm_q == F_ISSUE);
    assign wr_kind     = step.kind;
    assign wr_addr     = step.addr;
    assign wr_data     = step.data;
    assign busy        = (fsm_q != F_IDLE);
    assign panel_state = pst_q;
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_req,
    input logic [1:0]  wr_kind,
    input logic [7:0]  wr_addr,
    input logic [15:0] wr_data,
    input logic        wr_done,
    input logic        busy,
    input logic [1:0]  panel_state,
    input logic        video_en,
    input logic        seq_done,
    input logic        seq_fail,
    input logic        err_sticky
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_done) |=> (wr_req && $stable(wr_kind) && $stable(wr_addr) && $stable(wr_data)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_req);

    // R5
    video_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        video_en |-> (panel_state == 2'd1));

    // R10
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    // R10
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_fail |-> err_sticky);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !busy);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);
endmodule

bind pwrseq_top pwrseq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (wr_req),
    .wr_kind     (wr_kind),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_done     (wr_done),
    .busy        (busy),
    .panel_state (panel_state),
    .video_en    (video_en),
    .seq_done    (seq_done),
    .seq_fail    (seq_fail),
    .err_sticky  (err_sticky)
);

// File: tb/pwrseq_top_tb_top.sv
`timescale 1ns/1ps
module pwrseq_top_tb_top;
    localparam int CLK_HZ  = 20000;
    localparam int MS_CYC  = CLK_HZ / 1000;
    localparam int BOOT_MS = 90;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_enable = 0, req_disable = 0, req_suspend = 0, req_resume = 0;
    logic wr_req, wr_done = 0, wr_err = 0;
    logic [1:0] wr_kind, panel_state;
    logic [7:0] wr_addr;
    logic [15:0] wr_data;
    logic busy, video_en, seq_done, seq_fail, err_sticky;

    always #2.5 clk = ~clk;

    pwrseq_top #(.CLK_HZ(CLK_HZ), .BOOT_MS(BOOT_MS), .GAP_MS(1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_enable(req_enable), .req_disable(req_disable),
        .req_suspend(req_suspend), .req_resume(req_resume),
        .wr_req(wr_req), .wr_kind(wr_kind), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_done(wr_done), .wr_err(wr_err),
        .busy(busy), .panel_state(panel_state), .video_en(video_en),
        .seq_done(seq_done), .seq_fail(seq_fail), .err_sticky(err_sticky));

    typedef struct {
        logic [1:0]  kind;
        logic [7:0]  addr;
        logic [15:0] data;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    hs_t[$];
    int    n_run = 0, n_fail = 0;
    int    cyc = 0;
    int    err_at = -1;
    int    wr_in_seq = 0;
    bit    finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic [7:0] a, input logic [15:0] d, input string tag);
        item_t it;
        it.kind = k; it.addr = a; it.data = d; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // R3: wake ladder
    task automatic push_wake();
        for (int i = 0; i < 3; i++) push(2'd0, 8'h00, 16'h0000, "R3");
        push(2'd1, 8'hB0, 16'h0017, "R3");
    endtask

    // R4: switch-on list
    task automatic push_swon();
        push(2'd1, 8'hBC, 16'h0080, "R4");
        push(2'd1, 8'h3B, 16'h0000, "R4");
        push(2'd1, 8'hB0, 16'h0016, "R4");
        push(2'd2, 8'hB8, 16'hFFF9, "R4");
        push(2'd0, 8'h11, 16'h0000, "R4");
        push(2'd1, 8'hBA, 16'h0001, "R4");
        push(2'd1, 8'h3A, 16'h0060, "R4");
        push(2'd1, 8'hBD, 16'h0004, "R4");
        push(2'd0, 8'h29, 16'h0000, "R4");
    endtask

    // R6: power-down list
    task automatic push_down();
        push(2'd0, 8'h28, 16'h0000, "R6");
        push(2'd2, 8'hB8, 16'h8002, "R6");
        push(2'd0, 8'h10, 16'h0000, "R6");
    endtask

    // R7: teardown tail
    task automatic push_tail();
        push(2'd1, 8'hB0, 16'h0000, "R7");
    endtask

    // writer model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && wr_req) begin
                item_t it;
                hs_t.push_back(cyc);
                if (exp_q.size() == 0) begin
                    chk(0, "R8 unexpected write", {22'd0, wr_kind, wr_addr}, 0);
                end else begin
                    it = exp_q.pop_front();
                    chk(wr_kind == it.kind && wr_addr == it.addr && wr_data == it.data,
                        it.tag, {wr_kind, wr_addr, wr_data}, {it.kind, it.addr, it.data});
                end
                repeat (2) @(negedge clk);
                wr_err  = (wr_in_seq == err_at);
                wr_done = 1'b1;
                wr_in_seq++;
                @(negedge clk);
                wr_done = 1'b0;
                wr_err  = 1'b0;
            end
        end
    end

    task automatic pulse(input bit en, input bit dis, input bit sus, input bit res);
        @(negedge clk);
        req_enable = en; req_disable = dis; req_suspend = sus; req_resume = res;
        @(negedge clk);
        req_enable = 0; req_disable = 0; req_suspend = 0; req_resume = 0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!seq_done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 5000, {tag, " sequence end"}, n, 0);
    endtask

    task automatic quiet(input int n, input string tag);
        bit moved = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy || wr_req || seq_done) moved = 1;
        end
        chk(!moved, tag, moved, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("[TB] FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int boot_n;
        repeat (4) @(negedge clk);
        // R1
        chk(panel_state == 2'd0 && !video_en && busy && !wr_req, "R1 reset outputs",
            {panel_state, video_en, busy, wr_req}, 5'b00010);
        rst_n = 1'b1;
        boot_n = 0;
        @(negedge clk); boot_n++;
        chk(panel_state == 2'd0 && !video_en && busy && !wr_req, "R1 after release",
            {panel_state, video_en, busy, wr_req}, 5'b00010);
        // R2: request during boot is ignored
        repeat (98) @(negedge clk);
        boot_n += 98;
        pulse(1, 0, 0, 0);
        boot_n += 2;
        while (busy && boot_n < 4000) begin
            @(negedge clk);
            boot_n++;
        end
        chk(boot_n >= BOOT_MS * MS_CYC - 5 && boot_n <= BOOT_MS * MS_CYC + 5, "R2 boot length",
            boot_n, BOOT_MS * MS_CYC);
        chk(hs_t.size() == 0 && panel_state == 2'd0, "R2 no write in boot", hs_t.size(), 0);

        // R3 R4 R5: enable from disabled
        hs_t.delete(); wr_in_seq = 0; err_at = -1;
        push_wake(); push_swon();
        pulse(1, 0, 0, 0);
        wait_done("R3");
        chk(exp_q.size() == 0, "R3 list complete", exp_q.size(), 0);
        chk(panel_state == 2'd1 && video_en, "R5 active after enable", {panel_state, video_en}, 3'b011);
        chk(!seq_fail, "R10 clean enable", seq_fail, 0);
        chk(hs_t.size() == 13 && hs_t[1] - hs_t[0] >= MS_CYC && hs_t[3] - hs_t[2] >= MS_CYC,
            "R3 pause after null command", hs_t.size() == 13 ? hs_t[3] - hs_t[2] : -1, MS_CYC);
        chk(hs_t.size() == 13 && hs_t[4] - hs_t[3] < MS_CYC, "R3 no pause after B0",
            hs_t.size() == 13 ? hs_t[4] - hs_t[3] : -1, 4);

        // R8: enable and resume while active do nothing
        pulse(1, 0, 0, 0);
        quiet(40, "R8 enable while active");
        pulse(0, 0, 0, 1);
        quiet(40, "R8 resume while active");
        chk(panel_state == 2'd1 && video_en, "R8 active kept", {panel_state, video_en}, 3'b011);

        // R6: suspend, video off at acceptance
        wr_in_seq = 0;
        push_down();
        pulse(0, 0, 1, 0);
        chk(!video_en && busy, "R6 video off first", {video_en, busy}, 2'b01);
        pulse(0, 1, 0, 0);   // R8: ignored while busy
        wait_done("R6");
        chk(exp_q.size() == 0, "R6 list complete", exp_q.size(), 0);
        chk(panel_state == 2'd2 && !video_en, "R6 suspended", {panel_state, video_en}, 3'b100);
        pulse(0, 0, 1, 0);
        quiet(30, "R8 suspend while suspended");

        // R4 R5: resume from suspended
        wr_in_seq = 0;
        push_swon();
        pulse(0, 0, 0, 1);
        wait_done("R4");
        chk(exp_q.size() == 0, "R4 resume list complete", exp_q.size(), 0);
        chk(panel_state == 2'd1 && video_en, "R5 active after resume", {panel_state, video_en}, 3'b011);

        // R7 R10: disable with an error on the second write
        wr_in_seq = 0; err_at = 1;
        push_down(); push_tail();
        pulse(0, 1, 0, 0);
        wait_done("R7");
        err_at = -1;
        chk(exp_q.size() == 0, "R7 list complete", exp_q.size(), 0);
        chk(panel_state == 2'd0 && !video_en, "R7 disabled", {panel_state, video_en}, 0);
        chk(seq_fail && err_sticky, "R10 error reported", {seq_fail, err_sticky}, 2'b11);
        pulse(0, 1, 0, 0);
        quiet(30, "R8 disable while disabled");
        pulse(0, 0, 0, 1);
        quiet(30, "R8 resume while disabled");

        // R10: clean enable clears per-request fail, sticky stays
        wr_in_seq = 0;
        push_wake(); push_swon();
        pulse(1, 0, 0, 0);
        wait_done("R10");
        chk(!seq_fail && err_sticky, "R10 sticky kept", {seq_fail, err_sticky}, 2'b01);

        // R9: suspend and disable together -> disable
        wr_in_seq = 0;
        push_down(); push_tail();
        pulse(0, 1, 1, 0);
        wait_done("R9");
        chk(exp_q.size() == 0 && panel_state == 2'd0, "R9 disable wins", panel_state, 0);

        // R9: enable and resume together from suspended -> full enable
        wr_in_seq = 0;
        push_wake(); push_swon();
        pulse(1, 0, 0, 0);
        wait_done("R9 pre");
        wr_in_seq = 0;
        push_down();
        pulse(0, 0, 1, 0);
        wait_done("R9 pre2");
        wr_in_seq = 0;
        push_wake(); push_swon();
        pulse(1, 0, 0, 1);
        wait_done("R9");
        chk(exp_q.size() == 0 && panel_state == 2'd1, "R9 enable over resume", panel_state, 1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule